// File: doc/BRIEF.md
# Throttle Duty-Cycle Monitor

The block watches two throttle-request inputs, one per channel, and measures what share of a programmable window each was asserted. The window is counted in sample ticks, so the caller sets the time base by how often it pulses the tick enable. When a window closes, each channel publishes an 8-bit result in its current register. A two-point running average register is updated at the same boundary, and a byte of coarse status flags is decoded from the new result. These flags suit a sideband path that can carry status but not values.

A write to either channel's current register loads the written byte and restarts capture on both channels. While the sleep input is high, measurement stops, the current registers read zero and the averages are frozen. The first window completed after wake or reset loads its result directly into both the current and the average registers.

Top module: `throttle_duty_monitor`

## Requirements
- R1: The window lasts 256·2^k sample ticks, where k is `winSel`. Only cycles with `sampleTick` high are counted. The result is ceil(c/2^k) saturated at 255, where c is the number of counted ticks with the input high. The result lands in `curVal` on the clock edge of the window's last tick.
- R2: The result is 0 exactly when the input was high on none of the window's ticks. Any nonzero count gives at least 1.
- R3: At a window boundary that is not the first since wake or reset, `avgVal` becomes floor((old avgVal + old curVal)/2). `curVal` then takes the new result, so the average lags the current value by one window.
- R4: A cycle with `wrEn[i]` high while awake loads `wrData` into `curVal[i]` and restarts the window for both channels, discarding counts gathered so far.
- R5: While `sleepMode` is high, no ticks are counted, `curVal` of both channels reads 0 and `avgVal` holds. Writes are ignored during sleep.
- R6: The first window completed after reset or after `sleepMode` falls loads the result into both `curVal` and `avgVal`. Averaging resumes from the next window.
- R7: Status bits for result r are:
  - bit0: r > 0.
  - bit1: 1 ≤ r ≤ 32.
  - bit2: 33 ≤ r ≤ 64.
  - bit3: 65 ≤ r ≤ 128.
  - bit4: 129 ≤ r ≤ 192.
  - bit5: r ≥ 193 and the input was not high on every tick.
  - bit6: the input was high on every tick of the window.
- R8: Status bit7 is set when r is strictly greater than that channel's `userLimit`, sampled at the boundary.
- R9: The two channels are measured independently. Each has its own limit, current value, average and status.
- R10: Status bits change only at a window boundary and hold in every other cycle, including writes and sleep. Reset clears them, along with the counters and both value registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleTick | input | 1 | Sample enable; one counted tick per high cycle |
| winSel | input | 3 | Window length exponent k (256·2^k ticks) |
| thrIn | input | 2 | Synchronized throttle inputs, one per channel |
| userLimit | input | 2×8 | Per-channel limit for status bit7 |
| wrEn | input | 2 | Write strobe for each channel's current register |
| wrData | input | 8 | Data loaded by a write |
| sleepMode | input | 1 | High = low-power state, monitoring stopped |
| curVal | output | 2×8 | Current result per channel |
| avgVal | output | 2×8 | Running average per channel |
| statFlags | output | 2×8 | Status flags per channel (R7, R8) |

## Verification
On every cycle, the embedded properties check several behaviours:
- the one-window lag of the average;
- the direct load on the first window;
- the clear-and-hold behaviour in sleep;
- the restart of the tick counter on a write;
- the hold of the status byte between boundaries;
- the mutual exclusion of the band flags.

Other behaviours depend on long input histories, and only the bench scenarios show them:
- the exact ceiling-and-saturate scaling for each window length;
- the boundary values 32/33, 64/65, 128/129 and 192/193;
- the split between a full window and a 255 that is not full;
- the limit comparison at equality;
- the discarding of partial counts on a write.

// File: rtl/thr_mon_pkg.sv
package thr_mon_pkg;

  localparam int RES_W     = 8;
  localparam int SEL_W     = 3;
  localparam int MAX_SHIFT = (1 << SEL_W) - 1;
  localparam int CNT_W     = RES_W + MAX_SHIFT + 1;
  localparam int SUM_W     = CNT_W + 1;
  localparam int MAX_RES   = (1 << RES_W) - 1;

  // band lower edges, derived from full scale (1/8, 1/4, 1/2, 3/4 plus bias)
  localparam int EDGE_12 = (1 << (RES_W - 3)) + 1;
  localparam int EDGE_25 = (1 << (RES_W - 2)) + 1;
  localparam int EDGE_50 = (1 << (RES_W - 1)) + 1;
  localparam int EDGE_75 = (3 << (RES_W - 2)) + 1;

  typedef struct packed {
    logic tick;
    logic winEnd;
    logic restart;
    logic sleep;
    logic first;
  } ctrl_strobe_t;

  typedef struct packed {
    logic aboveLim;
    logic full;
    logic band75;
    logic band50;
    logic band25;
    logic band12;
    logic bandLow;
    logic any;
  } stat_t;

  function automatic logic [CNT_W-1:0] win_len(input logic [SEL_W-1:0] sel);
    return CNT_W'(1) << (RES_W + int'(sel));
  endfunction

  function automatic stat_t decode_stat(input logic [RES_W-1:0] r,
                                        input logic isFull,
                                        input logic [RES_W-1:0] lim);
    stat_t s;
    s.any      = (r != '0);
    s.bandLow  = (r != '0) && (int'(r) < EDGE_12);
    s.band12   = (int'(r) >= EDGE_12) && (int'(r) < EDGE_25);
    s.band25   = (int'(r) >= EDGE_25) && (int'(r) < EDGE_50);
    s.band50   = (int'(r) >= EDGE_50) && (int'(r) < EDGE_75);
    s.band75   = (int'(r) >= EDGE_75) && !isFull;
    s.full     = isFull;
    s.aboveLim = (r > lim);
    return s;
  endfunction

endpackage

// File: rtl/thr_mon_ctrl.sv
module thr_mon_ctrl
  import thr_mon_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleTick,
  input  logic              sleepMode,
  input  logic [NUM_CH-1:0] wrEn,
  input  logic [SEL_W-1:0]  winSel,
  output ctrl_strobe_t      strb
);

  logic [CNT_W-1:0] tickCnt;
  logic             firstPend;
  logic             restart;
  logic             tick;
  logic             winEnd;

  assign restart = (|wrEn) && !sleepMode;
  assign tick    = sampleTick && !sleepMode && !restart;
  assign winEnd  = tick && (tickCnt == win_len(winSel) - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt   <= '0;
      firstPend <= 1'b1;
    end else if (sleepMode) begin
      tickCnt   <= '0;
      firstPend <= 1'b1;
    end else if (restart) begin
      tickCnt   <= '0;
    end else if (tick) begin
      if (winEnd) begin
        tickCnt   <= '0;
        firstPend <= 1'b0;
      end else begin
        tickCnt <= tickCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strb.tick    = tick;
    strb.winEnd  = winEnd;
    strb.restart = restart;
    strb.sleep   = sleepMode;
    strb.first   = firstPend;
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (tickCnt == '0)); // R4
  AST_WAKE_FIRST: assert property (@(posedge clk) disable iff (rst)
    sleepMode |=> firstPend); // R6
  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    winEnd |-> (sampleTick && !sleepMode && !(|wrEn))); // R1
  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    sleepMode |=> (tickCnt == '0)); // R5

endmodule

// File: rtl/thr_mon_chan.sv
module thr_mon_chan
  import thr_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrl_strobe_t     strb,
  input  logic [SEL_W-1:0] winSel,
  input  logic             thrIn,
  input  logic [RES_W-1:0] userLimit,
  input  logic             wrHit,
  input  logic [RES_W-1:0] wrData,
  output logic [RES_W-1:0] curVal,
  output logic [RES_W-1:0] avgVal,
  output logic [RES_W-1:0] statVal
);

  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] cntNext;
  logic [SUM_W-1:0] roundAdd;
  logic [SUM_W-1:0] sumR;
  logic [SUM_W-1:0] shifted;
  logic [RES_W-1:0] result;
  logic             isFull;
  logic [RES_W-1:0] curReg;
  logic [RES_W-1:0] avgReg;
  logic [RES_W:0]   avgSum;
  logic [RES_W-1:0] avgNext;
  stat_t            statReg;

  always_comb begin
    cntNext  = countReg + CNT_W'(strb.tick & thrIn);
    roundAdd = (SUM_W'(1) << winSel) - SUM_W'(1);
    sumR     = SUM_W'(cntNext) + roundAdd;
    shifted  = sumR >> winSel;
    result   = (shifted > SUM_W'(MAX_RES)) ? RES_W'(MAX_RES) : shifted[RES_W-1:0];
    isFull   = (cntNext == win_len(winSel));
    avgSum   = {1'b0, avgReg} + {1'b0, curReg};
    avgNext  = avgSum[RES_W:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      countReg <= '0;
      curReg   <= '0;
      avgReg   <= '0;
      statReg  <= '0;
    end else if (strb.sleep) begin
      countReg <= '0;
      curReg   <= '0;
    end else if (strb.restart) begin
      countReg <= '0;
      if (wrHit) curReg <= wrData;
    end else if (strb.tick) begin
      if (strb.winEnd) begin
        countReg <= '0;
        curReg   <= result;
        avgReg   <= strb.first ? result : avgNext;
        statReg  <= decode_stat(result, isFull, userLimit);
      end else begin
        countReg <= cntNext;
      end
    end
  end

  assign curVal  = curReg;
  assign avgVal  = avgReg;
  assign statVal = statReg;

  AST_AVG_LAG: assert property (@(posedge clk) disable iff (rst)
    (strb.winEnd && !strb.first) |=>
      (avgReg == RES_W'(({1'b0, $past(avgReg)} + {1'b0, $past(curReg)}) >> 1))); // R3
  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (strb.winEnd && strb.first) |=> (avgReg == curReg)); // R6
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    strb.winEnd |=> ((curReg == '0) == ($past(cntNext) == '0))); // R2
  AST_SLEEP_CUR: assert property (@(posedge clk) disable iff (rst)
    strb.sleep |=> (curReg == '0)); // R5
  AST_SLEEP_AVG: assert property (@(posedge clk) disable iff (rst)
    strb.sleep |=> $stable(avgReg)); // R5
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.winEnd |=> $stable(statReg)); // R10
  AST_BAND_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({statReg.full, statReg.band75, statReg.band50,
              statReg.band25, statReg.band12, statReg.bandLow})); // R7
  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (rst)
    statReg.any == (curReg != '0) || !$past(strb.winEnd) ||
    statReg.any == |{statReg.full, statReg.band75, statReg.band50,
                     statReg.band25, statReg.band12, statReg.bandLow}); // R7

endmodule

// File: rtl/throttle_duty_monitor.sv
module throttle_duty_monitor
  import thr_mon_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sampleTick,
  input  logic [SEL_W-1:0]             winSel,
  input  logic [NUM_CH-1:0]            thrIn,
  input  logic [NUM_CH-1:0][RES_W-1:0] userLimit,
  input  logic [NUM_CH-1:0]            wrEn,
  input  logic [RES_W-1:0]             wrData,
  input  logic                         sleepMode,
  output logic [NUM_CH-1:0][RES_W-1:0] curVal,
  output logic [NUM_CH-1:0][RES_W-1:0] avgVal,
  output logic [NUM_CH-1:0][RES_W-1:0] statFlags
);

  ctrl_strobe_t strb;

  thr_mon_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sampleTick(sampleTick),
    .sleepMode (sleepMode),
    .wrEn      (wrEn),
    .winSel    (winSel),
    .strb      (strb)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    thr_mon_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .strb     (strb),
      .winSel   (winSel),
      .thrIn    (thrIn[ch]),
      .userLimit(userLimit[ch]),
      .wrHit    (wrEn[ch]),
      .wrData   (wrData),
      .curVal   (curVal[ch]),
      .avgVal   (avgVal[ch]),
      .statVal  (statFlags[ch])
    );
  end

endmodule

// File: tb/throttle_duty_monitor_tb.sv
module throttle_duty_monitor_tb;

  logic            clk = 1'b0;
  logic            rst;
  logic            sampleTick;
  logic [2:0]      winSel;
  logic [1:0]      thrIn;
  logic [1:0][7:0] userLimit;
  logic [1:0]      wrEn;
  logic [7:0]      wrData;
  logic            sleepMode;
  logic [1:0][7:0] curVal;
  logic [1:0][7:0] avgVal;
  logic [1:0][7:0] statFlags;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit       mFirst;
  int       mCur[2];
  int       mAvg[2];
  int       mStat[2];

  always #10 clk = ~clk;

  throttle_duty_monitor u_dut (
    .clk(clk), .rst(rst), .sampleTick(sampleTick), .winSel(winSel),
    .thrIn(thrIn), .userLimit(userLimit), .wrEn(wrEn), .wrData(wrData),
    .sleepMode(sleepMode), .curVal(curVal), .avgVal(avgVal),
    .statFlags(statFlags)
  );

  typedef struct packed {
    logic [2:0]  k;
    logic [15:0] on0;
    logic [15:0] on1;
    logic [7:0]  lim0;
    logic [7:0]  lim1;
    logic [7:0]  exp0;
    logic [7:0]  exp1;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS[NV] = '{
    '{3'd0, 16'd0,   16'd256, 8'd0,   8'd0,   8'd0,   8'd255},
    '{3'd0, 16'd1,   16'd32,  8'd0,   8'd40,  8'd1,   8'd32},
    '{3'd0, 16'd33,  16'd64,  8'd33,  8'd63,  8'd33,  8'd64},
    '{3'd0, 16'd65,  16'd128, 8'd10,  8'd200, 8'd65,  8'd128},
    '{3'd0, 16'd129, 16'd192, 8'd128, 8'd192, 8'd129, 8'd192},
    '{3'd0, 16'd193, 16'd255, 8'd0,   8'd0,   8'd193, 8'd255},
    '{3'd1, 16'd1,   16'd511, 8'd0,   8'd254, 8'd1,   8'd255},
    '{3'd2, 16'd4,   16'd5,   8'd0,   8'd2,   8'd1,   8'd2},
    '{3'd1, 16'd300, 16'd512, 8'd149, 8'd255, 8'd150, 8'd255}
  };

  function automatic int expRes(int on, int k);
    int q = (on + (1 << k) - 1) >> k;
    return (q > 255) ? 255 : q;
  endfunction

  function automatic int expStat(int r, bit full, int lim);
    logic [7:0] s;
    s[0] = (r > 0);
    s[1] = (r >= 1)   && (r <= 32);
    s[2] = (r >= 33)  && (r <= 64);
    s[3] = (r >= 65)  && (r <= 128);
    s[4] = (r >= 129) && (r <= 192);
    s[5] = (r >= 193) && !full;
    s[6] = full;
    s[7] = (r > lim);
    return int'(s);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit t, bit a0, bit a1);
    sampleTick = t;
    thrIn      = {a1, a0};
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(string req);
    for (int c = 0; c < 2; c++) begin
      chk({req, " cur"},  int'(curVal[c]),    mCur[c]);
      chk({req, " avg"},  int'(avgVal[c]),    mAvg[c]);
      chk({req, " stat"}, int'(statFlags[c]), mStat[c]);
    end
  endtask

  task automatic modelEnd(int r0, int r1, bit f0, bit f1);
    int rr[2];
    bit ff[2];
    rr[0] = r0; rr[1] = r1; ff[0] = f0; ff[1] = f1;
    for (int c = 0; c < 2; c++) begin
      if (mFirst) mAvg[c] = rr[c];
      else        mAvg[c] = (mAvg[c] + mCur[c]) / 2;
      mCur[c]  = rr[c];
      mStat[c] = expStat(rr[c], ff[c], int'(userLimit[c]));
    end
    mFirst = 0;
  endtask

  task automatic runWindow(int k, int on0, int on1);
    int len = 256 << k;
    winSel = 3'(k);
    for (int i = 0; i < len; i++) cyc(1'b1, i < on0, i < on1);
    sampleTick = 1'b0;
    modelEnd(expRes(on0, k), expRes(on1, k), on0 == len, on1 == len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sampleTick = 1'b0; winSel = 3'd0; thrIn = '0;
    userLimit = '0; wrEn = '0; wrData = '0; sleepMode = 1'b0;
    mFirst = 1;
    for (int c = 0; c < 2; c++) begin mCur[c] = 0; mAvg[c] = 0; mStat[c] = 0; end
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state: everything zero (R10)
    checkAll("R10 reset");

    // table walk: R1 scaling, R2 zero, R3 lag, R6 first load, R7 bands, R8 limit, R9 independence
    for (int v = 0; v < NV; v++) begin
      userLimit[0] = VECS[v].lim0;
      userLimit[1] = VECS[v].lim1;
      runWindow(int'(VECS[v].k), int'(VECS[v].on0), int'(VECS[v].on1));
      chk("R1 table cur0", int'(curVal[0]), int'(VECS[v].exp0));
      chk("R1 table cur1", int'(curVal[1]), int'(VECS[v].exp1));
      checkAll("R3 R7 R8 R9 table");
    end

    // R10: status holds mid-window
    winSel = 3'd0;
    for (int i = 0; i < 100; i++) cyc(1'b1, 1'b1, 1'b1);
    checkAll("R10 mid-window hold");

    // R4: write ch0 mid-window, partial count discarded for both channels
    wrData = 8'h5A; wrEn = 2'b01; sampleTick = 1'b0;
    @(posedge clk); @(negedge clk);
    wrEn = 2'b00;
    mCur[0] = 8'h5A;
    checkAll("R4 write load");
    runWindow(0, 10, 20);
    checkAll("R4 R3 restart");

    // R1: cycles without sampleTick are not counted
    for (int i = 0; i < 256; i++) begin
      cyc(1'b1, i < 10, 1'b0);
      cyc(1'b0, 1'b1, 1'b1);
    end
    sampleTick = 1'b0;
    modelEnd(10, 0, 0, 0);
    checkAll("R1 R2 tick gating");

    // R5: sleep clears current, holds average and status, ignores writes
    sleepMode = 1'b1;
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b1);
    wrData = 8'hC3; wrEn = 2'b11;
    @(posedge clk); @(negedge clk);
    wrEn = 2'b00;
    mCur[0] = 0; mCur[1] = 0; mFirst = 1;
    checkAll("R5 sleep");
    sleepMode = 1'b0;

    // R6: first window after wake loads both registers
    runWindow(0, 40, 80);
    checkAll("R6 wake first");
    chk("R6 avg equals cur", int'(avgVal[1]), int'(curVal[1]));
    runWindow(0, 200, 0);
    checkAll("R3 R6 averaging resumes");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule